// File: doc/BRIEF.md
# Logical-Device Plug-and-Play Configuration Space

This block holds the configuration registers of a multi-function I/O controller that hosts ten logical devices. Software reaches it through two byte-wide ports: an index port, which selects a register, and a data port, which reads or writes the selected register. The space stays locked until a two-byte key arrives on the index port, and a single exit byte locks it again.

Registers below index 0x30 form a global file; global entry 7 picks which logical device the upper indices (0x30 and above) refer to. Each device bank carries an activate byte, a pair of base-address bytes, a second base pair, an interrupt byte and a small group of device-specific bytes. A base address is committed when its low byte is written: it is aligned to eight bytes, checked against the device's set of legal addresses, replaced by the device default when it fails, and written back into the bank. The block drives every device's active flag, committed base address and interrupt number to the peripherals around it.

Top module: `pnp_cfg_space`

## Requirements
- R1: Two index-port writes of 0x55 in a row enter configuration mode; any other index-port byte written between them clears the partial key, and data-port writes do not affect the key.
- R2: Outside configuration mode both ports read 0xFF and data-port writes change no register and no output.
- R3: In configuration mode an index-port write of 0xAA leaves configuration mode; any other index-port byte becomes the current index, which the index port reads back.
- R4: A data-port write at an index below 0x30 stores the byte in the 48-entry global file and a data read at that index returns it.
- R5: Global entry 7 selects the device (0 floppy, 1 and 2 disk, 3 parallel, 4 serial one, 5 serial two, 6..9 others) addressed by indices 0x30 and above; a data read with a selected number above 9 returns 0xFF.
- R6: Data-port writes to a device bank are dropped when the selected device number is above 5.
- R7: Data-port writes at indices 0x70..0x7F are dropped when the selected device number is below 4.
- R8: A write to index 0x61 forms {low nibble of byte 0x60, written byte}, clears its three low bits, and replaces it with the device default if it is below 0x100 or not legal for the device; the result is written back into 0x60 (high nibble, upper bits zero) and 0x61 and becomes the device's base output.
- R9: A write to index 0x60 stores the byte but leaves the base output unchanged.
- R10: Legal bases: floppy 0x3F0, 0x370 (default 0x3F0); parallel 0x3BC, 0x378, 0x278 (default 0x378); both serial devices 0x3F8, 0x2F8, 0x338, 0x3E8, 0x2E8, 0x220, 0x238, 0x2E0, 0x228 (defaults 0x3F8 and 0x2F8); the other devices accept any aligned value.
- R11: A device's active output is high when its byte 0x30 is nonzero, and its interrupt output equals its byte 0x70.
- R12: After reset: mode locked, index 0; globals 0x03=3, 0x20=3, 0x21=1, 0x24=4, 0x26=0xF0, 0x27=3, all others 0; floppy active at 0x3F0, disk devices inactive at 0x1F0 and 0x170, parallel active at 0x378, serial one active at 0x3F8 with IRQ 4, serial two active at 0x2F8 with IRQ 3; every other bank byte 0.
- R13: Only bank indices 0x30, 0x60..0x63, 0x70, 0x74 and 0xF0..0xF7 hold storage; other bank indices read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the port chosen by port_sel_i |
| port_sel_i | input | 1 | 0 selects the index port, 1 the data port |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte of the port chosen by port_sel_i |
| dev_active_o | output | 10 | Active flag per device |
| dev_base_o | output | 120 | Committed base per device, 12 bits each, device 0 lowest |
| dev_irq_o | output | 80 | Interrupt byte per device, device 0 lowest |

## Verification
Directed sequences test the key with an interrupted match, a clean match and an exit, so a partial key that survives a wrong byte, or an exit byte taken as an index, shows up. Base writes go through legal values, aligned illegal values, values below 0x100 and unaligned bytes on each listed device, telling a missing alignment, a wrong default and a missing write-back apart, and a lone high-byte write separates commit-on-low from commit-on-either. Writes with device numbers on each side of 4, 6 and 10 and interrupt indices on protected devices separate the two protection rules. A seeded random mix of key bytes, indices, device selects and values then runs against a bench model of the whole space.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;
  localparam int N_DEV   = 10;
  localparam int N_GLOB  = 48;
  localparam int N_SLOT  = 16;
  localparam int BASE_W  = 12;
  localparam logic [3:0] SLOT_NONE = 4'd15;
  localparam logic [3:0] SLOT_ACT  = 4'd0;
  localparam logic [3:0] SLOT_BHI  = 4'd1;
  localparam logic [3:0] SLOT_BLO  = 4'd2;
  localparam logic [3:0] SLOT_IRQ  = 4'd5;

  // sparse bank: maps a bank index to a storage slot
  function automatic logic [3:0] slot_of(input logic [7:0] idx);
    logic [3:0] s;
    case (idx)
      8'h30: s = 4'd0;
      8'h60: s = 4'd1;
      8'h61: s = 4'd2;
      8'h62: s = 4'd3;
      8'h63: s = 4'd4;
      8'h70: s = 4'd5;
      8'h74: s = 4'd6;
      default: s = (idx[7:3] == 5'b11110) ? 4'd7 + {1'b0, idx[2:0]} : SLOT_NONE;
    endcase
    return s;
  endfunction

  function automatic logic [7:0] glob_rst(input int i);
    case (i)
      3, 'h20, 'h27: return 8'h03;
      'h21:          return 8'h01;
      'h24:          return 8'h04;
      'h26:          return 8'hF0;
      default:       return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] dev_rst(input int d, input int s);
    logic [7:0] v;
    v = 8'h00;
    case (d)
      0: case (s) 0: v = 8'h01; 1: v = 8'h03; 2: v = 8'hF0; default: ; endcase
      1: case (s) 1: v = 8'h01; 2: v = 8'hF0; default: ; endcase
      2: case (s) 1: v = 8'h01; 2: v = 8'h70; default: ; endcase
      3: case (s) 0: v = 8'h01; 1: v = 8'h03; 2: v = 8'h78; default: ; endcase
      4: case (s) 0: v = 8'h01; 1: v = 8'h03; 2: v = 8'hF8; 5: v = 8'h04; default: ; endcase
      5: case (s) 0: v = 8'h01; 1: v = 8'h02; 2: v = 8'hF8; 5: v = 8'h03; default: ; endcase
      default: ;
    endcase
    return v;
  endfunction

  function automatic logic [BASE_W-1:0] base_rst(input int d);
    logic [7:0] h, l;
    h = dev_rst(d, 1);
    l = dev_rst(d, 2);
    return {h[3:0], l[7:3], 3'b000};
  endfunction

  function automatic logic has_list(input int d);
    return (d == 0) || (d == 3) || (d == 4) || (d == 5);
  endfunction

  function automatic logic [BASE_W-1:0] base_dflt(input int d);
    case (d)
      0:       return 12'h3F0;
      3:       return 12'h378;
      4:       return 12'h3F8;
      5:       return 12'h2F8;
      default: return 12'h000;
    endcase
  endfunction

  function automatic logic is_legal(input int d, input logic [BASE_W-1:0] a);
    case (d)
      0: return (a == 12'h3F0) || (a == 12'h370);
      3: return (a == 12'h3BC) || (a == 12'h378) || (a == 12'h278);
      4, 5: case (a)
        12'h3F8, 12'h2F8, 12'h338, 12'h3E8, 12'h2E8,
        12'h220, 12'h238, 12'h2E0, 12'h228: return 1'b1;
        default: return 1'b0;
      endcase
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/pnp_key_unlock.sv
module pnp_key_unlock #(
  parameter logic [7:0] KEY_ENTER = 8'h55,
  parameter logic [7:0] KEY_EXIT  = 8'hAA
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_idx_i,
  input  logic [7:0] wdata_i,
  output logic       cfg_mode_o,
  output logic [7:0] idx_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_mode_o <= 1'b0;
      armed_q    <= 1'b0;
      idx_o      <= 8'h00;
    end else if (wr_idx_i) begin
      if (cfg_mode_o) begin
        if (wdata_i == KEY_EXIT) cfg_mode_o <= 1'b0;
        else                     idx_o      <= wdata_i;
      end else if (wdata_i == KEY_ENTER) begin
        cfg_mode_o <= armed_q;
        armed_q    <= ~armed_q;
      end else begin
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pnp_glob_regs.sv
module pnp_glob_regs #(
  parameter int N_GLOB = 48,
  parameter int SEL_ENTRY = 7,
  localparam int AW = $clog2(N_GLOB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic [7:0]    sel_o
);
  import pnp_cfg_pkg::*;

  logic [7:0] mem_q [N_GLOB];

  for (genvar i = 0; i < N_GLOB; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[i] <= glob_rst(i);
      else if (we_i && (addr_i == AW'(i)))    mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = (int'(addr_i) < N_GLOB) ? mem_q[addr_i] : 8'hFF;
  assign sel_o   = mem_q[SEL_ENTRY];
endmodule

// File: rtl/pnp_base_fix.sv
module pnp_base_fix #(
  parameter int DEV = 0
) (
  input  logic [pnp_cfg_pkg::BASE_W-1:0] raw_i,
  output logic [pnp_cfg_pkg::BASE_W-1:0] fixed_o
);
  import pnp_cfg_pkg::*;

  logic [BASE_W-1:0] aligned;
  assign aligned = {raw_i[BASE_W-1:3], 3'b000};

  if (has_list(DEV)) begin : g_list
    assign fixed_o = ((aligned < 12'h100) || !is_legal(DEV, aligned)) ? base_dflt(DEV) : aligned;
  end else begin : g_free
    assign fixed_o = aligned;
  end
endmodule

// File: rtl/pnp_dev_bank.sv
module pnp_dev_bank #(
  parameter int DEV = 0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [7:0]                     idx_i,
  input  logic [7:0]                     wdata_i,
  output logic [7:0]                     rdata_o,
  output logic                           active_o,
  output logic [pnp_cfg_pkg::BASE_W-1:0] base_o,
  output logic [7:0]                     irq_o
);
  import pnp_cfg_pkg::*;

  logic [7:0]        slot_q [N_SLOT];
  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] fixed;
  logic [3:0]        slot;
  logic [7:0]        bhi;

  assign slot = slot_of(idx_i);
  assign bhi  = slot_q[SLOT_BHI];

  pnp_base_fix #(.DEV(DEV)) u_fix (
    .raw_i   ({bhi[3:0], wdata_i}),
    .fixed_o (fixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_SLOT; s++) slot_q[s] <= dev_rst(DEV, s);
      base_q <= base_rst(DEV);
    end else if (we_i && (slot != SLOT_NONE)) begin
      if (slot == SLOT_BLO) begin
        slot_q[SLOT_BHI] <= {4'h0, fixed[BASE_W-1:8]};
        slot_q[SLOT_BLO] <= fixed[7:0];
        base_q           <= fixed;
      end else begin
        slot_q[slot] <= wdata_i;
      end
    end
  end

  assign rdata_o  = (slot == SLOT_NONE) ? 8'h00 : slot_q[slot];
  assign active_o = |slot_q[SLOT_ACT];
  assign base_o   = base_q;
  assign irq_o    = slot_q[SLOT_IRQ];
endmodule

// File: rtl/pnp_cfg_space.sv
module pnp_cfg_space #(
  parameter int N_DEV      = pnp_cfg_pkg::N_DEV,
  parameter int N_WR_DEV   = 6,
  parameter int N_PROT_DEV = 4,
  parameter int N_GLOB     = pnp_cfg_pkg::N_GLOB,
  localparam int BW        = pnp_cfg_pkg::BASE_W,
  localparam int DSW       = $clog2(N_DEV),
  localparam int GAW       = $clog2(N_GLOB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              port_sel_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [N_DEV-1:0]  dev_active_o,
  output logic [N_DEV*BW-1:0] dev_base_o,
  output logic [N_DEV*8-1:0]  dev_irq_o
);
  logic       cfg_mode;
  logic [7:0] idx_q;
  logic [7:0] dev_sel;
  logic [7:0] glob_rd;
  logic [7:0] bank_rd [N_DEV];
  logic       wr_dat, is_glob, bank_ok;

  pnp_key_unlock u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_idx_i   (wr_en_i && !port_sel_i),
    .wdata_i    (wdata_i),
    .cfg_mode_o (cfg_mode),
    .idx_o      (idx_q)
  );

  assign wr_dat  = wr_en_i && port_sel_i && cfg_mode;
  assign is_glob = (idx_q < 8'(N_GLOB));
  // write protection by selected device number
  assign bank_ok = !is_glob && (dev_sel < 8'(N_WR_DEV))
                   && !((idx_q[7:4] == 4'h7) && (dev_sel < 8'(N_PROT_DEV)));

  pnp_glob_regs #(.N_GLOB(N_GLOB)) u_glob (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_dat && is_glob),
    .addr_i  (idx_q[GAW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (glob_rd),
    .sel_o   (dev_sel)
  );

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    pnp_dev_bank #(.DEV(d)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (wr_dat && bank_ok && (dev_sel == 8'(d))),
      .idx_i    (idx_q),
      .wdata_i  (wdata_i),
      .rdata_o  (bank_rd[d]),
      .active_o (dev_active_o[d]),
      .base_o   (dev_base_o[d*BW +: BW]),
      .irq_o    (dev_irq_o[d*8 +: 8])
    );
  end

  always_comb begin
    if (!cfg_mode)                   rdata_o = 8'hFF;
    else if (!port_sel_i)            rdata_o = idx_q;
    else if (is_glob)                rdata_o = glob_rd;
    else if (dev_sel < 8'(N_DEV))    rdata_o = bank_rd[dev_sel[DSW-1:0]];
    else                             rdata_o = 8'hFF;
  end
endmodule

// File: rtl/pnp_cfg_space_chk.sv
module pnp_cfg_space_chk #(
  parameter int N_DEV = 10,
  localparam int BW = pnp_cfg_pkg::BASE_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               port_sel_i,
  input logic [7:0]         wdata_i,
  input logic [7:0]         rdata_o,
  input logic [N_DEV-1:0]   dev_active_o,
  input logic [N_DEV*BW-1:0] dev_base_o,
  input logic [N_DEV*8-1:0]  dev_irq_o,
  input logic               cfg_mode,
  input logic [7:0]         idx_q,
  input logic [7:0]         dev_sel
);
  import pnp_cfg_pkg::*;

  logic wr_d;
  assign wr_d = cfg_mode && wr_en_i && port_sel_i;

  assert_enter_key_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode) |-> $past(wr_en_i && !port_sel_i && (wdata_i == 8'h55)));

  assert_locked_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode |-> (rdata_o == 8'hFF));

  assert_exit_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode && wr_en_i && !port_sel_i && (wdata_i == 8'hAA)) |=> !cfg_mode);

  assert_hi_dev_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_d && (idx_q >= 8'h30) && (dev_sel > 8'd5))
    |=> ($stable(dev_base_o) && $stable(dev_active_o) && $stable(dev_irq_o)));

  assert_irq_protect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_d && (idx_q[7:4] == 4'h7) && (dev_sel < 8'd4)) |=> $stable(dev_irq_o));

  assert_hi_byte_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_d && (idx_q == 8'h60)) |=> $stable(dev_base_o));

  for (genvar d = 0; d < N_DEV; d++) begin : g_leg
    if (has_list(d)) begin : g_on
      assert_base_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_legal(d, dev_base_o[d*BW +: BW]));
    end
  end
endmodule

bind pnp_cfg_space pnp_cfg_space_chk #(.N_DEV(N_DEV)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .port_sel_i   (port_sel_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .dev_active_o (dev_active_o),
  .dev_base_o   (dev_base_o),
  .dev_irq_o    (dev_irq_o),
  .cfg_mode     (cfg_mode),
  .idx_q        (idx_q),
  .dev_sel      (dev_sel)
);

// File: tb/pnp_cfg_space_tb.sv
module pnp_cfg_space_tb;
  localparam int ND = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [ND-1:0] act;
  logic [ND*12-1:0] base;
  logic [ND*8-1:0] irq;

  always #2 clk = ~clk;

  pnp_cfg_space u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .port_sel_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .dev_active_o(act),
    .dev_base_o(base), .dev_irq_o(irq)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_glob [48];
  logic [7:0]  m_bank [ND][256];
  logic [11:0] m_base [ND];
  logic m_mode, m_armed;
  logic [7:0] m_idx;

  function automatic bit f_impl(input logic [7:0] i);
    return (i == 8'h30) || (i >= 8'h60 && i <= 8'h63) || (i == 8'h70)
        || (i == 8'h74) || (i >= 8'hF0 && i <= 8'hF7);
  endfunction

  function automatic bit f_ok(input int d, input logic [11:0] a);
    case (d)
      0: return a == 12'h3F0 || a == 12'h370;
      3: return a == 12'h3BC || a == 12'h378 || a == 12'h278;
      4, 5: return a == 12'h3F8 || a == 12'h2F8 || a == 12'h338 || a == 12'h3E8
                || a == 12'h2E8 || a == 12'h220 || a == 12'h238 || a == 12'h2E0 || a == 12'h228;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [11:0] f_fix(input int d, input logic [11:0] raw);
    logic [11:0] a;
    logic [11:0] df;
    a = raw & 12'hFF8;
    df = (d == 0) ? 12'h3F0 : (d == 3) ? 12'h378 : (d == 4) ? 12'h3F8 : 12'h2F8;
    if ((d == 0 || d == 3 || d == 4 || d == 5) && (a < 12'h100 || !f_ok(d, a))) return df;
    return a;
  endfunction

  function automatic logic [7:0] m_read(input logic s);
    int d;
    if (!m_mode) return 8'hFF;
    if (!s) return m_idx;
    if (m_idx < 8'h30) return m_glob[m_idx];
    d = int'(m_glob[7]);
    if (d > 9) return 8'hFF;
    return f_impl(m_idx) ? m_bank[d][m_idx] : 8'h00;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 48; i++) m_glob[i] = 8'h00;
    m_glob[3] = 3; m_glob['h20] = 3; m_glob['h21] = 1;
    m_glob['h24] = 4; m_glob['h26] = 8'hF0; m_glob['h27] = 3;
    for (int d = 0; d < ND; d++) begin
      for (int i = 0; i < 256; i++) m_bank[d][i] = 8'h00;
      m_base[d] = 12'h000;
    end
    m_bank[0][8'h30] = 1; m_base[0] = 12'h3F0;
    m_base[1] = 12'h1F0; m_base[2] = 12'h170;
    m_bank[3][8'h30] = 1; m_base[3] = 12'h378;
    m_bank[4][8'h30] = 1; m_base[4] = 12'h3F8; m_bank[4][8'h70] = 4;
    m_bank[5][8'h30] = 1; m_base[5] = 12'h2F8; m_bank[5][8'h70] = 3;
    for (int d = 0; d < ND; d++) begin
      m_bank[d][8'h60] = {4'h0, m_base[d][11:8]};
      m_bank[d][8'h61] = m_base[d][7:0];
    end
    m_mode = 0; m_armed = 0; m_idx = 0;
  endtask

  task automatic m_write(input logic s, input logic [7:0] v);
    int d;
    logic [11:0] f;
    if (!s) begin
      if (m_mode) begin
        if (v == 8'hAA) m_mode = 0; else m_idx = v;
      end else if (v == 8'h55) begin
        if (m_armed) begin m_mode = 1; m_armed = 0; end else m_armed = 1;
      end else m_armed = 0;
    end else if (m_mode) begin
      if (m_idx < 8'h30) m_glob[m_idx] = v;
      else begin
        d = int'(m_glob[7]);
        if (d < 6 && !(m_idx[7:4] == 4'h7 && d < 4) && f_impl(m_idx)) begin
          if (m_idx == 8'h61) begin
            f = f_fix(d, {m_bank[d][8'h60][3:0], v});
            m_bank[d][8'h60] = {4'h0, f[11:8]};
            m_bank[d][8'h61] = f[7:0];
            m_base[d] = f;
          end else m_bank[d][m_idx] = v;
        end
      end
    end
  endtask

  task automatic chk(input string tag, input logic [127:0] a, input logic [127:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic chk_outs(input string tag);
    logic [ND-1:0] ea;
    logic [ND*12-1:0] eb;
    logic [ND*8-1:0] ei;
    for (int d = 0; d < ND; d++) begin
      ea[d] = |m_bank[d][8'h30];
      eb[d*12 +: 12] = m_base[d];
      ei[d*8 +: 8] = m_bank[d][8'h70];
    end
    chk({tag, " active"}, 128'(act), 128'(ea));
    chk({tag, " base"}, 128'(base), 128'(eb));
    chk({tag, " irq"}, 128'(irq), 128'(ei));
  endtask

  task automatic wr(input logic s, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1; sel = s; wdata = v;
    @(negedge clk);
    wr_en = 0;
    m_write(s, v);
  endtask

  task automatic rd(input logic s, input string tag);
    @(negedge clk);
    wr_en = 0; sel = s;
    #1 chk(tag, 128'(rdata), 128'(m_read(s)));
  endtask

  task automatic set(input logic [7:0] i, input logic [7:0] v);
    wr(0, i); wr(1, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int unsigned seed;
    int r;
    logic [11:0] pick [9];
    pick = '{12'h3F8, 12'h2F8, 12'h338, 12'h3E8, 12'h2E8, 12'h220, 12'h3BC, 12'h370, 12'h278};
    seed = 32'd1234;
    void'($urandom(seed));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    #1 chk_outs("R12");
    rd(0, "R2 locked index"); rd(1, "R2 locked data");
    // R2 locked writes ignored
    wr(1, 8'h00); chk_outs("R2"); rd(1, "R2");
    // R1 interrupted key
    wr(0, 8'h55); wr(0, 8'h12); wr(0, 8'h55); rd(0, "R1 partial");
    wr(1, 8'h00); wr(0, 8'h55); rd(0, "R1 data-port write keeps key");
    wr(0, 8'h55); wr(0, 8'h55); rd(0, "R1 entered");
    // R3 index readback, R4 globals
    wr(0, 8'h26); rd(0, "R3"); rd(1, "R12 global 0x26");
    set(8'h2A, 8'h5C); rd(1, "R4");
    // R8/R10 serial one
    set(8'h07, 8'h04);
    set(8'h61, 8'hE8); chk_outs("R8 legal"); 
    set(8'h60, 8'h02); chk_outs("R9 high byte only");
    set(8'h61, 8'hEC); chk_outs("R8 aligned legal");
    set(8'h61, 8'h00); chk_outs("R10 illegal to default");
    wr(0, 8'h60); rd(1, "R8 writeback hi"); wr(0, 8'h61); rd(1, "R8 writeback lo");
    set(8'h60, 8'h00); set(8'h61, 8'h80); chk_outs("R8 below 0x100");
    set(8'h60, 8'hF3); set(8'h61, 8'h38); chk_outs("R8 upper bits dropped");
    // R11 irq / active on serial one
    set(8'h70, 8'h05); chk_outs("R11 irq");
    set(8'h30, 8'h00); chk_outs("R11 active off");
    // R7 floppy irq protected
    set(8'h07, 8'h00); set(8'h70, 8'h09); chk_outs("R7"); rd(1, "R7 readback");
    set(8'h07, 8'h03); set(8'h60, 8'h02); set(8'h61, 8'hBC); chk_outs("R10 parallel illegal");
    set(8'h07, 8'h01); set(8'h60, 8'h05); set(8'h61, 8'h55); chk_outs("R10 free list");
    // R6 and R5
    set(8'h07, 8'h07); set(8'h30, 8'h01); chk_outs("R6"); rd(1, "R6 readback");
    set(8'h07, 8'h0C); rd(1, "R5 out-of-range device");
    // R13 unimplemented index
    set(8'h07, 8'h04); set(8'h40, 8'h77); rd(1, "R13");
    wr(0, 8'hF3); wr(1, 8'h6B); rd(1, "R13 stored slot");
    // R3 exit
    wr(0, 8'hAA); rd(0, "R3 exit"); rd(1, "R3 exit data");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      r = int'($urandom_range(0, 99));
      if (r < 8) wr(0, ($urandom_range(0, 3) == 0) ? 8'hAA : 8'h55);
      else if (r < 30) begin
        case ($urandom_range(0, 5))
          0: v = 8'h07;
          1: v = 8'h60;
          2: v = 8'h61;
          3: v = 8'h70;
          4: v = 8'h30;
          default: v = 8'($urandom_range(0, 255));
        endcase
        if (v != 8'hAA && v != 8'h55) wr(0, v);
      end else if (r < 65) begin
        if (m_idx == 8'h07) v = 8'($urandom_range(0, 11));
        else if (m_idx == 8'h60) v = {4'h0, pick[$urandom_range(0, 8)][11:8]};
        else if (m_idx == 8'h61 && $urandom_range(0, 1) == 1) v = pick[$urandom_range(0, 8)][7:0];
        else v = 8'($urandom_range(0, 255));
        wr(1, v);
        chk_outs("R11 random");
      end else rd(1'($urandom_range(0, 1)), "R5 random read");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule